// File: doc/BRIEF.md
# Timeslot Circular Capture/Playback Buffer

This block attaches two 16-byte receive rings and two 16-byte transmit rings to the time slots of a 32-slot, 8-bit-per-slot framed stream. The surrounding framer presents one slot per valid cycle: the slot number, the received byte and the outgoing byte. It also raises a multiframe strobe on slot 0 of the first frame of each 16-frame multiframe. Each ring takes or gives exactly one byte per frame at the slot it is assigned to. One pass over a ring therefore covers one multiframe.

A receive ring is armed by software and waits. It fires on the first byte at its slot that differs from a shared detect word in any bit enabled by a shared mask. From that byte on it stores 16 consecutive frames of the slot. It then raises a done flag and disarms itself. A transmit ring that is connected substitutes its contents for the outgoing byte of its slot. It starts with entry 0 at the next multiframe boundary and repeats every multiframe until it is disconnected.

A byte-wide register port with a combinational read path selects slots, sets the detect word and mask, arms and connects the rings, and reads or loads ring entries by a 4-bit index.

Top module: `slot_ring_buf`

## Requirements
- R1: After reset the slot-select, detect, mask and control registers read 0, and every outgoing byte equals the incoming transmit byte.
- R2: An armed receive ring does not fire while the masked bits of its slot's byte equal the detect word. It fires on the first such byte that differs, and stores that byte at index 0.
- R3: After firing, a receive ring stores its slot's byte from 16 consecutive frames at indices 0 to 15. It then sets its done flag and clears its arm bit, and later frames change none of its entries. Writing its arm bit as 1 clears done.
- R4: Detect-word bits whose mask bit is 0 never cause a firing, so a mask of 0 never fires.
- R5: Bytes in slots other than a ring's selected slot neither fire nor fill that ring, and each receive ring acts only on its own slot and arm bit.
- R6: A newly connected transmit ring leaves the stream untouched until the next multiframe strobe. From then on, in frame k of each multiframe, the byte of its slot is entry k. This includes slot 0 in the same cycle as the strobe.
- R7: When a transmit ring's connect bit is 0 its slot carries the incoming transmit byte, from the first slot after the write.
- R8: A write to a transmit ring entry is ignored while that ring is playing, and is stored when the ring is idle.
- R9: Register map on a 7-bit address. With bit 6 = 0, bits 5:4 pick the ring (0 rx0, 1 rx1, 2 tx0, 3 tx1) and bits 3:0 the entry; receive entries are read-only. With bit 6 = 1, bits 2:0 pick 0 rx0 slot, 1 rx1 slot, 2 tx0 slot, 3 tx1 slot, 4 detect word, 5 mask, 6 control. Control bits are [0] arm rx0, [1] arm rx1, [2] connect tx0, [3] connect tx1, and read-only [4] done rx0, [5] done rx1, [6] tx0 playing, [7] tx1 playing.
- R10: A playing transmit ring returns to entry 0 at every multiframe strobe, so its 16 entries repeat once per multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | 1 | A slot is presented this cycle |
| slot_idx | input | 5 | Number of the presented slot |
| mf_start | input | 1 | Multiframe boundary, with slot 0 of frame 0 |
| rx_byte | input | 8 | Received byte of the presented slot |
| tx_in | input | 8 | Normal outgoing byte of the presented slot |
| tx_out | output | 8 | Outgoing byte after ring substitution |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
The case that is hardest to reach from the ports is the end of a capture. On that edge a ring must store its last byte, stop, set done and drop its arm bit. Bytes that would fire it again arrive in the very next frames. To get there, the stimulus first shows the armed ring matching frames, then 16 frames of distinct bytes. It reads the status one frame before and one frame after the end. It then sends frames whose bytes mismatch the detect word, so any late overwrite or second firing shows in the stored entries. Transmit alignment is reached by connecting a ring in the middle of a multiframe, and also with the ring on slot 0, where the strobe and the first substituted byte share one cycle.

// File: rtl/slot_ring_buf.sv
module slot_ring_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int SLOTS = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int SW = $clog2(SLOTS),
  localparam int AW = PW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_vld,
  input  logic [SW-1:0] slot_idx,
  input  logic          mf_start,
  input  logic [W-1:0]  rx_byte,
  input  logic [W-1:0]  tx_in,
  output logic [W-1:0]  tx_out,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata
);
  localparam int NB = 2;

  logic [W-1:0]  det, msk;
  logic [SW-1:0] rsel [NB];
  logic [SW-1:0] tsel [NB];
  logic [NB-1:0] arm, cap, done, cn, go, rhit, thit;
  logic [PW-1:0] rptr [NB];
  logic [PW-1:0] tptr [NB];
  logic [PW-1:0] tidx [NB];
  logic [W-1:0]  tdat [NB];
  logic [W-1:0]  rxm [NB][DEPTH];
  logic [W-1:0]  txm [NB][DEPTH];

  wire          ctl_area = reg_addr[AW-1];
  wire [2:0]    csub     = reg_addr[2:0];
  wire [1:0]    bsel     = reg_addr[AW-2:PW];
  wire [PW-1:0] bidx     = reg_addr[PW-1:0];
  wire          cfg_we   = reg_we && ctl_area;
  wire          ctl_we   = cfg_we && csub == 3'd6;
  wire          mf       = slot_vld && mf_start;
  wire          miss     = |((rx_byte ^ det) & msk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det <= '0;
      msk <= '0;
      cn  <= '0;
      for (int i = 0; i < NB; i++) begin
        rsel[i] <= '0;
        tsel[i] <= '0;
      end
    end else if (cfg_we) begin
      case (csub)
        3'd0: rsel[0] <= reg_wdata[SW-1:0];
        3'd1: rsel[1] <= reg_wdata[SW-1:0];
        3'd2: tsel[0] <= reg_wdata[SW-1:0];
        3'd3: tsel[1] <= reg_wdata[SW-1:0];
        3'd4: det     <= reg_wdata;
        3'd5: msk     <= reg_wdata;
        3'd6: cn      <= reg_wdata[2*NB-1:NB];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_ring
    assign rhit[g] = slot_vld && slot_idx == rsel[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        arm[g]  <= 1'b0;
        cap[g]  <= 1'b0;
        done[g] <= 1'b0;
        rptr[g] <= '0;
      end else begin
        if (rhit[g] && cap[g]) begin
          rptr[g] <= rptr[g] + 1'b1;
          if (rptr[g] == PW'(DEPTH - 1)) begin
            cap[g]  <= 1'b0;
            arm[g]  <= 1'b0;
            done[g] <= 1'b1;
          end
        end else if (rhit[g] && arm[g] && miss) begin
          rptr[g] <= PW'(1);
          cap[g]  <= 1'b1;
        end
        if (ctl_we && !cap[g]) begin
          arm[g] <= reg_wdata[g];
          if (reg_wdata[g]) done[g] <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk)
      if (rhit[g] && (cap[g] || (arm[g] && miss)))
        rxm[g][cap[g] ? rptr[g] : '0] <= rx_byte;

    assign tidx[g] = mf ? '0 : tptr[g];
    assign thit[g] = slot_vld && slot_idx == tsel[g] && cn[g] && (go[g] || mf);
    assign tdat[g] = txm[g][tidx[g]];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        go[g]   <= 1'b0;
        tptr[g] <= '0;
      end else begin
        if (!cn[g])  go[g] <= 1'b0;
        else if (mf) go[g] <= 1'b1;
        if (thit[g]) tptr[g] <= tidx[g] + 1'b1;
        else if (mf) tptr[g] <= '0;
      end
    end

    always_ff @(posedge clk)
      if (reg_we && !ctl_area && bsel == 2'(NB + g) && !(go[g] && cn[g]))
        txm[g][bidx] <= reg_wdata;
  end

  assign tx_out = thit[0] ? tdat[0] : thit[1] ? tdat[1] : tx_in;

  always_comb begin
    reg_rdata = '0;
    if (ctl_area) begin
      case (csub)
        3'd0: reg_rdata = W'(rsel[0]);
        3'd1: reg_rdata = W'(rsel[1]);
        3'd2: reg_rdata = W'(tsel[0]);
        3'd3: reg_rdata = W'(tsel[1]);
        3'd4: reg_rdata = det;
        3'd5: reg_rdata = msk;
        3'd6: reg_rdata = W'({go & cn, done, cn, arm});
        default: reg_rdata = '0;
      endcase
    end else begin
      case (bsel)
        2'd0: reg_rdata = rxm[0][bidx];
        2'd1: reg_rdata = rxm[1][bidx];
        2'd2: reg_rdata = txm[0][bidx];
        default: reg_rdata = txm[1][bidx];
      endcase
    end
  end
endmodule

// File: rtl/slot_ring_buf_chk.sv
module slot_ring_buf_chk #(
  parameter int W  = 8,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slot_vld,
  input logic          mf_start,
  input logic [W-1:0]  tx_in,
  input logic [W-1:0]  tx_out,
  input logic [1:0]    arm,
  input logic [1:0]    cap,
  input logic [1:0]    done,
  input logic [1:0]    cn,
  input logic [1:0]    go,
  input logic [PW-1:0] tptr0
);
  // R7
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cn == 2'b00) |-> (tx_out == tx_in));

  // R6
  late_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go[0]) |-> $past(mf_start && slot_vld));

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_start && slot_vld) |=> (tptr0 <= PW'(1)));

  // R2
  trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap[0]) |-> $past(arm[0]));

  // R3
  done_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[0]) |-> (!arm[0] && !cap[0]));

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done[1] |-> !cap[1]);
endmodule

bind slot_ring_buf slot_ring_buf_chk #(.W(W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .mf_start(mf_start),
  .tx_in(tx_in), .tx_out(tx_out), .arm(arm), .cap(cap), .done(done),
  .cn(cn), .go(go), .tptr0(tptr[0])
);

// File: tb/sim_slot_ring_buf.sv
`timescale 1ns/1ps
module sim_slot_ring_buf;
  logic       clk = 0, rst_n = 0, slot_vld = 0, mf_start = 0, reg_we = 0;
  logic [4:0] slot_idx = '0;
  logic [7:0] rx_byte = '0, tx_in = '0, reg_wdata = '0;
  logic [6:0] reg_addr = '0;
  logic [7:0] tx_out, reg_rdata, d;
  int checks = 0, fails = 0;

  localparam logic [6:0] ARS0 = 7'h40, ARS1 = 7'h41, ATS0 = 7'h42,
                         ADET = 7'h44, AMSK = 7'h45, ACTL = 7'h46;
  // {detect, mask, byte at slot 5, fires}
  localparam logic [24:0] VEC [6] = '{
    {8'hA5, 8'hFF, 8'hA5, 1'b0}, {8'hA5, 8'hFF, 8'hA4, 1'b1},
    {8'hA5, 8'hF0, 8'hAA, 1'b0}, {8'hA5, 8'hF0, 8'h55, 1'b1},
    {8'hA5, 8'h00, 8'h5A, 1'b0}, {8'h00, 8'h01, 8'h01, 1'b1}};

  slot_ring_buf u0 (.clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_idx(slot_idx),
    .mf_start(mf_start), .rx_byte(rx_byte), .tx_in(tx_in), .tx_out(tx_out),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] v);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic run_frame(input bit mf, input logic [7:0] b0, b1,
                           input bit rep, input logic [4:0] rs, input logic [7:0] rv,
                           input string req);
    logic [7:0] e;
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      slot_vld = 1; slot_idx = 5'(s); mf_start = mf && s == 0;
      rx_byte = (s == 5) ? b0 : (s == 7) ? b1 : 8'(8'h40 + s);
      tx_in = 8'(8'h60 + s);
      #1 e = (rep && 5'(s) == rs) ? rv : tx_in;
      chk(tx_out == e, req, tx_out, e);
    end
    @(negedge clk); slot_vld = 0; mf_start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(ACTL, d); chk(d == 8'h00, "R1", d, 8'h00);
    rd(ADET, d); chk(d == 8'h00, "R1", d, 8'h00);
    rd(ARS0, d); chk(d == 8'h00, "R1", d, 8'h00);
    run_frame(1, 8'h00, 8'h00, 0, 0, 0, "R1");

    wr(ARS0, 8'd5);
    wr(ARS1, 8'd7);
    rd(ARS1, d); chk(d == 8'd7, "R9", d, 8'd7);

    // R2 R4 R5 vector table
    foreach (VEC[i]) begin
      wr(ADET, VEC[i][24:17]);
      wr(AMSK, VEC[i][16:9]);
      wr(ACTL, 8'h01);
      run_frame(0, VEC[i][8:1], 8'h00, 0, 0, 0, "R5");
      for (int f = 0; f < 15; f++) run_frame(0, VEC[i][24:17], 8'h00, 0, 0, 0, "R7");
      rd(ACTL, d);
      chk(d[4] == VEC[i][0], "R2 R4 fire", {7'b0, d[4]}, {7'b0, VEC[i][0]});
      if (VEC[i][0]) begin
        rd(7'h00, d); chk(d == VEC[i][8:1], "R2 first byte", d, VEC[i][8:1]);
        rd(7'h01, d); chk(d == VEC[i][24:17], "R3 second byte", d, VEC[i][24:17]);
      end
      wr(ACTL, 8'h00);
    end

    // R3 full capture, end and re-arm
    wr(ADET, 8'h00); wr(AMSK, 8'hFF); wr(ACTL, 8'h01);
    run_frame(0, 8'h00, 8'h00, 0, 0, 0, "R2");
    run_frame(0, 8'h00, 8'h00, 0, 0, 0, "R2");
    for (int k = 0; k < 16; k++) begin
      run_frame(0, 8'(8'h10 + k), 8'h00, 0, 0, 0, "R3");
      if (k == 14) begin
        rd(ACTL, d); chk(d[4] == 0 && d[0] == 1, "R3 before end", d, 8'h01);
      end
    end
    rd(ACTL, d); chk(d[4] == 1 && d[0] == 0, "R3 done", d, 8'h10);
    for (int f = 0; f < 3; f++) run_frame(0, 8'hEE, 8'h00, 0, 0, 0, "R3");
    for (int k = 0; k < 16; k++) begin
      rd(7'(k), d); chk(d == 8'(8'h10 + k), "R3 entry", d, 8'(8'h10 + k));
    end
    wr(ACTL, 8'h01);
    rd(ACTL, d); chk(d[4] == 0, "R3 rearm", d, 8'h01);
    wr(ACTL, 8'h00);

    // R5 second receive ring on its own slot
    wr(ACTL, 8'h02);
    run_frame(0, 8'h99, 8'h3C, 0, 0, 0, "R5");
    for (int f = 0; f < 15; f++) run_frame(0, 8'h99, 8'h00, 0, 0, 0, "R5");
    rd(ACTL, d); chk(d[5] == 1 && d[4] == 0, "R5 status", d, 8'h20);
    rd(7'h10, d); chk(d == 8'h3C, "R5 rx1 entry", d, 8'h3C);
    rd(7'h00, d); chk(d == 8'h10, "R5 rx0 untouched", d, 8'h10);

    // R6 R8 R10 transmit
    wr(ATS0, 8'd9);
    for (int k = 0; k < 16; k++) wr(7'(8'h20 + k), 8'(8'hC0 + k));
    rd(7'h25, d); chk(d == 8'hC5, "R8 idle write", d, 8'hC5);
    wr(ACTL, 8'h04);
    run_frame(0, 8'h00, 8'h00, 0, 0, 0, "R6 wait");
    rd(ACTL, d); chk(d[6] == 0 && d[2] == 1, "R9 not playing", d, 8'h04);
    for (int f = 0; f < 16; f++) begin
      run_frame(f == 0, 8'h00, 8'h00, 1, 5'd9, 8'(8'hC0 + f), "R6");
      if (f == 3) begin
        wr(7'h23, 8'h00);
        rd(7'h23, d); chk(d == 8'hC3, "R8 write while playing", d, 8'hC3);
        rd(ACTL, d); chk(d[6] == 1, "R9 playing", d, 8'h44);
      end
    end
    run_frame(1, 8'h00, 8'h00, 1, 5'd9, 8'hC0, "R10");
    run_frame(0, 8'h00, 8'h00, 1, 5'd9, 8'hC1, "R10");
    wr(ACTL, 8'h00);
    run_frame(0, 8'h00, 8'h00, 0, 0, 0, "R7");
    wr(7'h23, 8'h77);
    rd(7'h23, d); chk(d == 8'h77, "R8 write after stop", d, 8'h77);

    // R6 slot 0 shares the strobe cycle
    wr(ATS0, 8'd0);
    wr(ACTL, 8'h04);
    run_frame(1, 8'h00, 8'h00, 1, 5'd0, 8'hC0, "R6 slot0");
    run_frame(0, 8'h00, 8'h00, 1, 5'd0, 8'hC1, "R6 slot0");
    wr(ACTL, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule